// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller collects interrupt requests from a set of on-chip sources and from four external request pins, then resolves them into one normal interrupt request for the processor together with the index of the winning source. Each source has its own configuration word. The word holds an enable bit, a trigger mode and a 3-bit priority (eight levels). Edge-triggered requests are held in a pending latch. Level-sensitive requests count only while the input stays at its active level.

The processor reads the vector address to acknowledge the interrupt. The read returns the winning source index and records that source's priority level as in service. While a level is in service, only a request of strictly higher priority raises the request line again, so interrupts nest. An end-of-interrupt write retires the highest level in service and restores the previous one. A separate fast interrupt output follows only the dedicated fast interrupt pin. One of the internal inputs is meant for the parallel I/O block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are 0, vec_o is the default vector 8 (N_INT+N_EXT), and every configuration word reads back 0, so every source is masked.
- R2: A source whose enable bit (bit 5 of its configuration word at address = source index) is 0 is never selected, whatever its input does.
- R3: For an external source (indices 4..7 = ext_src[0..3]), mode 00 (bits 4:3) requests while the input is 1 and mode 01 requests while the input is 0. Neither mode latches: the request ends when the input leaves its active level.
- R4: For an external source, mode 10 latches a pending request on a rising edge and mode 11 latches one on a falling edge. The pending request stays set until that source is acknowledged.
- R5: For an internal source (indices 0..3 = int_src[0..3]), bit 3 of the mode is stored as 0. Mode 01 therefore behaves as high level and mode 11 behaves as rising edge.
- R6: Among the enabled requesting sources, the one with the largest priority value (bits 2:0, 7 highest) wins. When priorities are equal, the lower index wins. vec_o shows the winner's index while irq_o is 1, and shows 8 otherwise.
- R7: A read of address 8 returns vec_o on bus_rdata. If irq_o is 1, the read acknowledges the winner: its priority level is marked as in service and its edge pending bit is cleared. A read while irq_o is 0 returns 8 and changes nothing.
- R8: While any level is in service, irq_o is raised only by a request whose priority is strictly above the highest level in service. A write to address 9 (end of interrupt) retires the highest level in service.
- R9: fiq_o equals fiq_i delayed by one clock, and no other input affects it.
- R10: A write to a source's configuration word clears that source's edge pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | N_INT | Internal peripheral requests |
| ext_src | input | N_EXT | External request pins |
| fiq_i | input | 1 | Dedicated fast interrupt pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (address 8 acknowledges) |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | VW | Winning source index, or 8 when no request |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle, so that an acknowledge and an end of interrupt cannot overlap. They also assume that source inputs are plain synchronous levels. The bench drives every bus access as a single-cycle strobe on its own and changes inputs only on the falling clock edge. The nesting checks rely on the bench always acknowledging a request before it retires the level with an end-of-interrupt write.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_INT = 4,
  parameter int N_EXT = 4,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] int_src,
  input  logic [N_EXT-1:0] ext_src,
  input  logic             fiq_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o,
  output logic             fiq_o,
  output logic [$clog2(N_INT+N_EXT+1)-1:0] vec_o
);
  localparam int NSRC     = N_INT + N_EXT;
  localparam int VW       = $clog2(NSRC + 1);
  localparam int NLVL     = 8;
  localparam int VEC_ADDR = NSRC;
  localparam int EOI_ADDR = NSRC + 1;

  logic [5:0]      cfg [NSRC];
  logic [NSRC-1:0] raw, src_q, src_qq, epend, edge_hit, req;
  logic [NLVL-1:0] isr;
  logic [VW-1:0]   best_idx;
  logic [2:0]      best_pri, top;
  logic            any_req, take, eoi;

  assign raw  = {ext_src, int_src};
  assign take = bus_rd && bus_addr == AW'(VEC_ADDR) && irq_o;
  assign eoi  = bus_wr && bus_addr == AW'(EOI_ADDR);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      edge_hit[i] = cfg[i][3] ? (src_qq[i] & ~src_q[i]) : (src_q[i] & ~src_qq[i]);
      req[i] = cfg[i][5] & (cfg[i][4] ? epend[i] : (src_q[i] ^ cfg[i][3]));
    end
  end

  always_comb begin
    any_req  = 1'b0;
    best_idx = '0;
    best_pri = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i] && (!any_req || cfg[i][2:0] > best_pri)) begin
        any_req  = 1'b1;
        best_idx = VW'(i);
        best_pri = cfg[i][2:0];
      end
  end

  always_comb begin
    top = '0;
    for (int j = 0; j < NLVL; j++)
      if (isr[j]) top = 3'(j);
  end

  assign irq_o = any_req && (isr == '0 || best_pri > top);
  assign vec_o = irq_o ? best_idx : VW'(NSRC);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(VEC_ADDR))
      bus_rdata = DW'(vec_o);
    else
      for (int i = 0; i < NSRC; i++)
        if (bus_addr == AW'(i)) bus_rdata = DW'(cfg[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      src_qq <= '0;
      fiq_o  <= 1'b0;
    end else begin
      src_q  <= raw;
      src_qq <= src_q;
      fiq_o  <= fiq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) cfg[i] <= '0;
      epend <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (bus_wr && bus_addr == AW'(i)) begin
          cfg[i]   <= {bus_wdata[5:4], (i < N_INT) ? 1'b0 : bus_wdata[3], bus_wdata[2:0]};
          epend[i] <= 1'b0;
        end else if (edge_hit[i] && cfg[i][4])
          epend[i] <= 1'b1;
        else if (take && best_idx == VW'(i))
          epend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      isr <= '0;
    else if (take)
      isr[best_pri] <= 1'b1;
    else if (eoi && isr != '0)
      isr[top] <= 1'b0;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int VW   = 4,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fiq_i,
  input logic            fiq_o,
  input logic            irq_o,
  input logic [VW-1:0]   vec_o,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [7:0]      isr,
  input logic [NSRC-1:0] req
);
  a_r9_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fiq_o == $past(fiq_i));

  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o <= VW'(NSRC));

  a_r6_irq_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o < VW'(NSRC)) && req[vec_o]);

  a_r7_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == AW'(NSRC) && irq_o)
      |=> $countones(isr) == $past($countones(isr)) + 1);

  a_r8_eoi_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == AW'(NSRC + 1) && isr != '0)
      |=> $countones(isr) + 1 == $past($countones(isr)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_i(fiq_i), .fiq_o(fiq_o), .irq_o(irq_o),
  .vec_o(vec_o), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .isr(isr), .req(req)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic [3:0] int_src = 0, ext_src = 0;
  logic       fiq_i = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq_o, fiq_o;
  logic [3:0] vec_o;
  int checks = 0, fails = 0;
  bit done = 0;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic setcfg(int idx, int pri, int mode, int en);
    wr(idx, (en << 5) | (mode << 3) | pri);
  endtask

  task automatic ack(string tag, int exp);
    bus_rd = 1; bus_addr = 4'd8;
    #1 chk(tag, int'(bus_rdata), exp);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic eoi();
    wr(9, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 fiq", int'(fiq_o), 0);
    chk("R1 vec", int'(vec_o), 8);
    for (int i = 0; i < 8; i++) begin
      bus_addr = 4'(i); #1 chk("R1 cfg", int'(bus_rdata), 0);
    end

    int_src = '1; ext_src = '1;
    for (int t = 0; t < 24; t++) begin
      int bp = -1, bi = 8;
      for (int i = 0; i < 8; i++) begin
        int p = (i * t + t) % 4 + (t % 5);
        int e = ((i + t) % 3) != 0;
        setcfg(i, p, 0, e);
        if (e && p > bp) begin bp = p; bi = i; end
      end
      cyc(3);
      chk("R6 vec", int'(vec_o), bi);
      chk("R6 irq", int'(irq_o), bi != 8);
    end
    for (int i = 0; i < 8; i++) setcfg(i, 0, 0, 0);
    int_src = 0; ext_src = 0;
    cyc(3);
    chk("R2 all masked", int'(irq_o), 0);

    ext_src[1] = 1; setcfg(5, 6, 0, 0); cyc(3);
    chk("R2 masked irq", int'(irq_o), 0);
    chk("R2 masked vec", int'(vec_o), 8);
    ext_src[1] = 0; cyc(2);

    setcfg(5, 3, 1, 1); cyc(3);
    chk("R3 low level active", int'(irq_o), 1);
    chk("R3 low level vec", int'(vec_o), 5);
    ext_src[1] = 1; cyc(3);
    chk("R3 low level released", int'(irq_o), 0);
    setcfg(5, 0, 0, 0);

    ack("R7 spurious read", 8);
    ext_src[0] = 1; setcfg(4, 0, 0, 1); cyc(3);
    chk("R7 spurious no change", int'(irq_o), 1);
    setcfg(4, 2, 0, 1); cyc(1);
    ack("R7 ack vec", 4);
    chk("R8 same level held", int'(irq_o), 0);
    chk("R7 vec default", int'(vec_o), 8);
    ext_src[1] = 1; setcfg(5, 2, 0, 1); cyc(3);
    chk("R8 equal pri no preempt", int'(irq_o), 0);
    setcfg(5, 5, 0, 1); cyc(1);
    chk("R8 higher preempts", int'(irq_o), 1);
    ack("R8 nested ack", 5);
    ext_src[1] = 0; cyc(3);
    eoi(); cyc(1);
    chk("R8 back to level 2", int'(irq_o), 0);
    eoi(); cyc(1);
    chk("R8 stack empty", int'(irq_o), 1);
    chk("R8 stack empty vec", int'(vec_o), 4);
    setcfg(4, 0, 0, 0); setcfg(5, 0, 0, 0); ext_src = 0; cyc(3);

    setcfg(6, 3, 2, 1); cyc(1);
    ext_src[2] = 1; cyc(1); ext_src[2] = 0; cyc(3);
    chk("R4 rise latched", int'(irq_o), 1);
    chk("R4 rise vec", int'(vec_o), 6);
    ack("R4 rise ack", 6);
    eoi(); cyc(1);
    chk("R4 cleared by ack", int'(irq_o), 0);

    ext_src[2] = 1; cyc(1); ext_src[2] = 0; cyc(3);
    chk("R10 latched", int'(irq_o), 1);
    setcfg(6, 3, 2, 1); cyc(1);
    chk("R10 cfg write clears", int'(irq_o), 0);
    setcfg(6, 0, 0, 0);

    ext_src[3] = 1; cyc(3);
    setcfg(7, 4, 3, 1); cyc(3);
    chk("R4 fall idle", int'(irq_o), 0);
    ext_src[3] = 0; cyc(3);
    chk("R4 fall latched", int'(irq_o), 1);
    ack("R4 fall ack", 7);
    chk("R4 fall in service", int'(irq_o), 0);
    eoi(); cyc(1);
    chk("R4 fall cleared", int'(irq_o), 0);
    setcfg(7, 0, 0, 0);

    setcfg(0, 1, 1, 1);
    bus_addr = 0; #1 chk("R5 mode bit stored 0", int'(bus_rdata), (1 << 5) | 1);
    cyc(3);
    chk("R5 mode01 low input", int'(irq_o), 0);
    int_src[0] = 1; cyc(3);
    chk("R5 mode01 as high level", int'(irq_o), 1);
    chk("R5 vec", int'(vec_o), 0);
    int_src[0] = 0; setcfg(0, 0, 0, 0);
    setcfg(1, 2, 3, 1); cyc(3);
    int_src[1] = 1; cyc(3);
    chk("R5 mode11 as rise", int'(irq_o), 1);
    ack("R5 rise ack", 1);
    eoi(); int_src[1] = 0; cyc(3);
    chk("R5 fall ignored", int'(irq_o), 0);
    setcfg(1, 0, 0, 0);

    fiq_i = 1; cyc(1);
    chk("R9 fiq high", int'(fiq_o), 1);
    chk("R9 irq untouched", int'(irq_o), 0);
    fiq_i = 0; ext_src[0] = 1; setcfg(4, 7, 0, 1); cyc(3);
    chk("R9 irq does not drive fiq", int'(fiq_o), 0);
    chk("R9 irq active", int'(irq_o), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule